// File: doc/BRIEF.md
# Multi-Pin Input Capture Timer

This block is a timer channel in which several capture pins share one free-running 16-bit up-counter. A run bit gates the counter. Each pin has its own synchronizer and edge detector, and each pin's edge mode is set on its own. When the chosen transition appears on a pin, the counter value at that moment is copied into that pin's capture register and the pin's status flag is set.

A flag stays set until software pulses the pin's bit on the clear input. The interrupt line is asserted whenever any flag is set and the interrupt enable bit for that pin is also set. Firmware uses the block to timestamp external events. The time between two events is the difference of two captured values, taken modulo 2^16.

The number of pins and the counter width are set in the package. The defaults are four pins and a 16-bit counter.

Top module: `capt_timer`

## Requirements
- R1: The counter holds 0 after reset. On each rising clock edge where `cntRun` is 1, the counter increases by one. On each rising clock edge where `cntRun` is 0, the counter keeps its value.
- R2: When the counter is at 0xFFFF and `cntRun` is 1, the next rising clock edge sets it to 0x0000.
- R3: A pin level applied before rising edge k passes through a two-stage synchronizer. If that level forms a selected transition, the pin's capture register loads the value the counter held just before edge k+2.
- R4: Each pin's 2-bit edge mode is read from `edgeSel[2*i+1:2*i]`. 00 selects rising edges, 01 selects falling edges, 10 selects both edges, and 11 disables capture on that pin.
- R5: A capture sets that pin's flag. A capture on one pin leaves the capture registers and flags of the other pins unchanged.
- R6: A set flag stays set until its `flagClr` bit is 1 at a rising clock edge. The flag reads 0 after that edge, as long as no capture occurs on the same edge.
- R7: If a clear and a capture for the same pin fall on the same rising edge, the flag is 1 after that edge.
- R8: `irq` is 1 exactly when, for at least one pin, both the flag and the `irqEn` bit are 1.
- R9: After reset, the counter, all capture registers, all flags and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cntRun | input | 1 | Counter run bit |
| captIn | input | 4 | Asynchronous capture pins |
| edgeSel | input | 8 | Edge mode, 2 bits per pin |
| flagClr | input | 4 | Flag clear strobe, 1 bit per pin |
| irqEn | input | 4 | Interrupt enable, 1 bit per pin |
| captVal | output | 64 | Capture registers, pin i at bits [16*i+15:16*i] |
| flags | output | 4 | Sticky capture flags |
| count | output | 16 | Free-running counter value |
| irq | output | 1 | Interrupt request |

## Verification
A flag clear and a new capture can land on the same pin in the same cycle. The bench provokes this in two ways. Random stimulus toggles pins and pulses clears independently. A directed case also holds a pin's clear high while its edge passes through the synchronizer. The flag must read 1 after that shared edge and 0 one cycle later. Counter wrap during a capture is covered by a long run past 0xFFFF with sparse pin activity.

// File: rtl/capt_pkg.sv
package capt_pkg;
  parameter int CAPT_PINS  = 4;
  parameter int CAPT_CNT_W = 16;

  typedef enum logic [1:0] {
    EDGE_RISE = 2'b00,
    EDGE_FALL = 2'b01,
    EDGE_BOTH = 2'b10,
    EDGE_OFF  = 2'b11
  } edgeMode_t;

  typedef struct packed {
    logic [CAPT_PINS-1:0] capture;
    logic [CAPT_PINS-1:0] clear;
    logic                 advance;
  } captStrobe_t;
endpackage

// File: rtl/capt_ctrl.sv
module capt_ctrl
  import capt_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   cntRun,
  input  logic [CAPT_PINS-1:0]   captIn,
  input  logic [2*CAPT_PINS-1:0] edgeSel,
  input  logic [CAPT_PINS-1:0]   flagClr,
  output captStrobe_t            strobe
);
  localparam int SYNC_STAGES = 2;

  logic [CAPT_PINS-1:0] pinSync [SYNC_STAGES];
  logic [CAPT_PINS-1:0] pinPrev;
  logic [CAPT_PINS-1:0] hit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < SYNC_STAGES; s++) pinSync[s] <= '0;
      pinPrev <= '0;
    end else begin
      pinSync[0] <= captIn;
      for (int s = 1; s < SYNC_STAGES; s++) pinSync[s] <= pinSync[s-1];
      pinPrev <= pinSync[SYNC_STAGES-1];
    end
  end

  for (genvar i = 0; i < CAPT_PINS; i++) begin : g_det
    logic      cur;
    logic      rise;
    logic      fall;
    edgeMode_t mode;
    assign cur  = pinSync[SYNC_STAGES-1][i];
    assign rise = cur & ~pinPrev[i];
    assign fall = ~cur & pinPrev[i];
    assign mode = edgeMode_t'(edgeSel[2*i +: 2]);
    always_comb begin
      unique case (mode)
        EDGE_RISE: hit[i] = rise;
        EDGE_FALL: hit[i] = fall;
        EDGE_BOTH: hit[i] = rise | fall;
        default:   hit[i] = 1'b0;
      endcase
    end
  end

  assign strobe.capture = hit;
  assign strobe.clear   = flagClr;
  assign strobe.advance = cntRun;
endmodule

// File: rtl/capt_datapath.sv
module capt_datapath
  import capt_pkg::*;
(
  input  logic                            clk,
  input  logic                            rstN,
  input  captStrobe_t                     strobe,
  input  logic [CAPT_PINS-1:0]            irqEn,
  output logic [CAPT_PINS*CAPT_CNT_W-1:0] captVal,
  output logic [CAPT_PINS-1:0]            flags,
  output logic [CAPT_CNT_W-1:0]           count,
  output logic                            irq
);
  localparam logic [CAPT_CNT_W-1:0] CNT_ONE = CAPT_CNT_W'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               count <= '0;
    else if (strobe.advance) count <= count + CNT_ONE;
  end

  for (genvar i = 0; i < CAPT_PINS; i++) begin : g_pin
    logic [CAPT_CNT_W-1:0] held;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        held     <= '0;
        flags[i] <= 1'b0;
      end else begin
        if (strobe.capture[i]) held <= count;
        flags[i] <= strobe.capture[i] | (flags[i] & ~strobe.clear[i]);
      end
    end
    assign captVal[i*CAPT_CNT_W +: CAPT_CNT_W] = held;
  end

  assign irq = |(flags & irqEn);
endmodule

// File: rtl/capt_timer.sv
module capt_timer
  import capt_pkg::*;
(
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            cntRun,
  input  logic [CAPT_PINS-1:0]            captIn,
  input  logic [2*CAPT_PINS-1:0]          edgeSel,
  input  logic [CAPT_PINS-1:0]            flagClr,
  input  logic [CAPT_PINS-1:0]            irqEn,
  output logic [CAPT_PINS*CAPT_CNT_W-1:0] captVal,
  output logic [CAPT_PINS-1:0]            flags,
  output logic [CAPT_CNT_W-1:0]           count,
  output logic                            irq
);
  captStrobe_t strobe;

  capt_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cntRun(cntRun), .captIn(captIn),
    .edgeSel(edgeSel), .flagClr(flagClr), .strobe(strobe)
  );

  capt_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .irqEn(irqEn),
    .captVal(captVal), .flags(flags), .count(count), .irq(irq)
  );
endmodule

// File: rtl/capt_timer_chk.sv
module capt_timer_chk
  import capt_pkg::*;
(
  input logic                            clk,
  input logic                            rstN,
  input logic                            cntRun,
  input logic [CAPT_PINS-1:0]            flagClr,
  input logic [CAPT_PINS-1:0]            irqEn,
  input logic [CAPT_PINS*CAPT_CNT_W-1:0] captVal,
  input logic [CAPT_PINS-1:0]            flags,
  input logic [CAPT_CNT_W-1:0]           count,
  input logic                            irq
);
  localparam logic [CAPT_CNT_W-1:0] CNT_MAX = '1;

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    cntRun && count != CNT_MAX |=> count == $past(count) + CAPT_CNT_W'(1)); // R1
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !cntRun |=> $stable(count)); // R1
  AST_CNT_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    cntRun && count == CNT_MAX |=> count == '0); // R2

  for (genvar i = 0; i < CAPT_PINS; i++) begin : g_chk
    AST_CAPT_VALUE: assert property (@(posedge clk) disable iff (!rstN)
      !flags[i] ##1 flags[i] |-> captVal[i*CAPT_CNT_W +: CAPT_CNT_W] == $past(count)); // R3
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
      flags[i] && !flagClr[i] |=> flags[i]); // R6
    AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (!rstN)
      flags[i] && irqEn[i] |-> irq); // R8
  end
endmodule

bind capt_timer capt_timer_chk u_chk (
  .clk(clk), .rstN(rstN), .cntRun(cntRun), .flagClr(flagClr), .irqEn(irqEn),
  .captVal(captVal), .flags(flags), .count(count), .irq(irq)
);

// File: tb/sim_capt_timer.sv
`timescale 1ns/1ps
module sim_capt_timer;
  localparam int NP = 4;
  localparam int W  = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cntRun = 1'b0;
  logic [NP-1:0]   captIn = '0;
  logic [2*NP-1:0] edgeSel = '0;
  logic [NP-1:0]   flagClr = '0;
  logic [NP-1:0]   irqEn = '0;
  logic [NP*W-1:0] captVal;
  logic [NP-1:0]   flags;
  logic [W-1:0]    count;
  logic            irq;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  capt_timer u0 (
    .clk(clk), .rstN(rstN), .cntRun(cntRun), .captIn(captIn), .edgeSel(edgeSel),
    .flagClr(flagClr), .irqEn(irqEn), .captVal(captVal), .flags(flags),
    .count(count), .irq(irq)
  );

  // reference state derived from the requirements
  logic [W-1:0]    mCount;
  logic [NP*W-1:0] mCapt;
  logic [NP-1:0]   mFlag, mS1, mS2, mPrev;
  bit sawWrap = 0;

  function automatic bit edgeHit(input logic [1:0] mode, input logic now, input logic old);
    case (mode)
      2'b00: return now & ~old;
      2'b01: return ~now & old;
      2'b10: return now ^ old;
      default: return 1'b0;
    endcase
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mCount = '0; mCapt = '0; mFlag = '0; mS1 = '0; mS2 = '0; mPrev = '0;
    end else begin
      for (int p = 0; p < NP; p++) begin
        bit h;
        h = edgeHit(edgeSel[2*p +: 2], mS2[p], mPrev[p]);
        if (h) mCapt[p*W +: W] = mCount;
        mFlag[p] = h | (mFlag[p] & ~flagClr[p]);
      end
      if (cntRun) begin
        if (mCount == 16'hFFFF) sawWrap = 1;
        mCount = mCount + 16'd1;
      end
      mPrev = mS2; mS2 = mS1; mS1 = captIn;
    end
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic checkAll();
    check("R1 count", 64'(count), 64'(mCount));
    check("R5 flags", 64'(flags), 64'(mFlag));
    check("R8 irq", 64'(irq), 64'(|(mFlag & irqEn)));
    check("R3 capture", captVal, mCapt);
  endtask

  task automatic step(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      checkAll();
    end
  endtask

  initial begin
    process::self().srandom(32'h5eed);
    repeat (3) @(negedge clk);
    check("R9 reset count", 64'(count), 64'h0);
    check("R9 reset flags", 64'(flags), 64'h0);
    check("R9 reset irq", 64'(irq), 64'h0);
    check("R9 reset capture", captVal, 64'h0);
    rstN = 1'b1;

    // R1: counter held while run low
    step(5);
    check("R1 hold", 64'(count), 64'h0);
    cntRun = 1'b1;
    step(4);
    check("R1 advance", 64'(count), 64'h4);

    // R4: mode 11 ignores toggles on pin 1
    edgeSel = 8'b00_00_11_00;
    captIn[1] = 1'b1; step(4);
    captIn[1] = 1'b0; step(4);
    check("R4 disabled mode", 64'(flags[1]), 64'h0);

    // R3/R5: rising edge on pin 2, capture value and isolation
    begin
      logic [W-1:0] exp;
      exp = count + 16'd2;
      captIn[2] = 1'b1;
      step(3);
      check("R3 latency", 64'(captVal[2*W +: W]), 64'(exp));
      check("R5 flag set", 64'(flags), 64'b0100);
    end

    // R6: flag stays without clear, then clears
    step(6);
    check("R6 sticky", 64'(flags[2]), 64'h1);
    flagClr[2] = 1'b1; step(1); flagClr[2] = 1'b0;
    check("R6 cleared", 64'(flags[2]), 64'h0);

    // R7: clear held while capture lands on pin 0 (both edges)
    edgeSel = 8'b10_10_10_10;
    flagClr[0] = 1'b1;
    @(negedge clk); captIn[0] = ~captIn[0];
    step(3);
    check("R7 capture wins", 64'(flags[0]), 64'h1);
    step(1);
    check("R7 then cleared", 64'(flags[0]), 64'h0);
    flagClr[0] = 1'b0;

    // R8: enable gating
    irqEn = 4'b0000;
    @(negedge clk); captIn[3] = ~captIn[3];
    step(4);
    check("R8 masked", 64'(irq), 64'h0);
    irqEn = 4'b1000; step(1);
    check("R8 enabled", 64'(irq), 64'h1);

    // random mix
    for (int n = 0; n < 3000; n++) begin
      @(negedge clk);
      checkAll();
      if ($urandom_range(0, 9) == 0) edgeSel = 8'($urandom);
      if ($urandom_range(0, 3) == 0) captIn = captIn ^ 4'($urandom);
      flagClr = ($urandom_range(0, 2) == 0) ? 4'($urandom) : 4'b0;
      irqEn = ($urandom_range(0, 15) == 0) ? 4'($urandom) : irqEn;
      cntRun = ($urandom_range(0, 7) != 0);
    end

    // long run past wrap with sparse events (R2)
    cntRun = 1'b1; flagClr = '0;
    for (int n = 0; n < 66000; n++) begin
      @(negedge clk);
      checkAll();
      if ($urandom_range(0, 499) == 0) captIn = captIn ^ 4'($urandom);
      if ($urandom_range(0, 499) == 0) flagClr = 4'($urandom); else flagClr = '0;
    end
    check("R2 wrap seen", 64'(sawWrap), 64'h1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule